// File: doc/BRIEF.md
# Banked Level-Interrupt Controller

This block gathers a set of level-sensitive interrupt lines, grouped into banks of 32, and presents a single interrupt request to a processor. Software reaches it through a small 32-bit register bus. Each bank has a mask register. The mask can be written directly, or changed bit by bit through two write-only aliases: one sets mask bits and one clears them. A read-only pending register per bank shows which unmasked lines are asserted.

When no interrupt is being serviced and at least one unmasked line is asserted, the controller latches the number of the lowest-numbered pending line and raises its request output. The latched number stays fixed until software writes an acknowledge bit. On the cycle after the acknowledge, the controller picks again from the lines that are still pending.

A soft reset can be started from a configuration register. It returns every register to its power-on state over a short fixed sequence and then reports completion through a separate status flag.

The block also holds several registers as plain storage, so that software can save and restore them: an autoidle bit, protection, idle and threshold words, and one 32-bit level word per interrupt.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, `irq_req` is 0, every pending register reads 0 even while all inputs are high, the active register reads 0, and the status register at 0x14 reads 1 in bit 0.
- R2: Writing the set alias of bank n (0x8C + 0x20·n) forces to 1 the mask bits that are 1 in the data and leaves the other mask bits unchanged. The mask reads back at 0x84 + 0x20·n.
- R3: Writing the clear alias of bank n (0x88 + 0x20·n) forces to 0 the mask bits that are 1 in the data and leaves the others unchanged. A direct write to 0x84 + 0x20·n replaces the whole mask.
- R4: The pending register of bank n (0x98 + 0x20·n) reads the input levels of that bank ANDed with the inverted mask. Input i belongs to bank i/32, at bit i mod 32.
- R5: When nothing is latched and some unmasked input is pending, the lowest-numbered pending input is latched on the next clock edge. `irq_req` rises with it, and the active register at 0x40 returns that number in bits [6:0].
- R6: While an interrupt is latched, its number and `irq_req` stay unchanged even if its input drops or is masked, and even if other inputs change.
- R7: Writing 1 to bit 0 of the control register at 0x48 while an interrupt is latched clears `irq_req` and the active register on that edge. If a line is still pending, a new selection is made on the following edge.
- R8: Writing 1 to bit 1 of 0x10 starts a soft reset that lasts SRST_CYCLES cycles. During it, status bit 0 reads 0 and bus writes are ignored. Afterwards every register is back to its R1 state, with status bit 0 at 1.
- R9: Bit 0 of 0x10 (autoidle) is read/write storage when bit 1 of the written data is 0. Bit 1 of 0x10 reads as 0.
- R10: The protection (0x4C), idle (0x50) and threshold (0x68) words, and the level words at 0x100 + 4·i for every input i, read back the value last written.
- R11: Reads of any offset with no readable register, including the aliases, the control register and offsets past the last level word, return 0.
- R12: The revision register at 0x00 returns REV_MAJOR in bits [7:4] and REV_MINOR in bits [3:0], which is 0x21 with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lvl | input | NUM_BANKS*32 | Level-sensitive interrupt inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
Selection is exercised with a table of input and unmask patterns:

- a single line;
- two lines in different banks;
- a low line masked while a higher line in the last bank is unmasked;
- the very first and the very last input;
- lines that are asserted but fully masked.

Together these separate a correct lowest-first choice from a highest-first choice, from a choice that ignores the mask, and from a per-bank choice. Directed sequences then check the hold behaviour: the latched line drops, or is masked, before the acknowledge. They also confirm that a reselection follows exactly one cycle after the acknowledge. Finally, a soft reset is issued with a live interrupt, and writes made during the reset are shown to have no effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BANK_W    = 32;
    localparam int MAX_BANKS = 4;
    localparam int NUM_W     = 7;

    // Register offsets (byte addresses)
    localparam int OFF_REV     = 'h000;
    localparam int OFF_SYSCFG  = 'h010;
    localparam int OFF_SYSSTAT = 'h014;
    localparam int OFF_ACTIVE  = 'h040;
    localparam int OFF_CTRL    = 'h048;
    localparam int OFF_PROT    = 'h04C;
    localparam int OFF_IDLE    = 'h050;
    localparam int OFF_THRESH  = 'h068;
    localparam int OFF_MASK    = 'h084;
    localparam int OFF_CLR     = 'h088;
    localparam int OFF_SET     = 'h08C;
    localparam int OFF_PEND    = 'h098;
    localparam int BANK_STRIDE = 'h020;
    localparam int OFF_LVL     = 'h100;

    typedef enum logic [3:0] {
        K_NONE, K_REV, K_SYSCFG, K_SYSSTAT, K_ACTIVE, K_CTRL,
        K_PROT, K_IDLE, K_THRESH, K_MASK, K_CLR, K_SET, K_PEND, K_LVL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [1:0]       bank;
        logic [NUM_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic             vld;
        logic [NUM_W-1:0] num;
    } active_t;

    function automatic dec_t decode_addr(input logic [11:0] a, input int nbanks);
        dec_t d;
        d.kind = K_NONE;
        d.bank = '0;
        d.idx  = '0;
        if      (a == 12'(OFF_REV))     d.kind = K_REV;
        else if (a == 12'(OFF_SYSCFG))  d.kind = K_SYSCFG;
        else if (a == 12'(OFF_SYSSTAT)) d.kind = K_SYSSTAT;
        else if (a == 12'(OFF_ACTIVE))  d.kind = K_ACTIVE;
        else if (a == 12'(OFF_CTRL))    d.kind = K_CTRL;
        else if (a == 12'(OFF_PROT))    d.kind = K_PROT;
        else if (a == 12'(OFF_IDLE))    d.kind = K_IDLE;
        else if (a == 12'(OFF_THRESH))  d.kind = K_THRESH;
        for (int b = 0; b < MAX_BANKS; b++) begin
            if (b < nbanks) begin
                if (a == 12'(OFF_MASK + b * BANK_STRIDE)) begin d.kind = K_MASK; d.bank = 2'(b); end
                if (a == 12'(OFF_CLR  + b * BANK_STRIDE)) begin d.kind = K_CLR;  d.bank = 2'(b); end
                if (a == 12'(OFF_SET  + b * BANK_STRIDE)) begin d.kind = K_SET;  d.bank = 2'(b); end
                if (a == 12'(OFF_PEND + b * BANK_STRIDE)) begin d.kind = K_PEND; d.bank = 2'(b); end
            end
        end
        if (int'(a) >= OFF_LVL && int'(a) < OFF_LVL + 4 * nbanks * BANK_W && a[1:0] == 2'b00) begin
            d.kind = K_LVL;
            d.idx  = NUM_W'((a - 12'(OFF_LVL)) >> 2);
        end
        return d;
    endfunction

endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_mask,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [31:0]  wdata,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] mask,
    output logic [W-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst)          mask <= '1;
        else if (wr_mask) mask <= wdata[W-1:0];
        else if (wr_set)  mask <= mask | wdata[W-1:0];
        else if (wr_clr)  mask <= mask & ~wdata[W-1:0];
    end

    assign pend = lvl & ~mask;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int N = 96
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pend,
    input  logic         ack,
    output active_t      active
);
    logic             found;
    logic [NUM_W-1:0] lowest;

    always_comb begin
        found  = 1'b0;
        lowest = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found  = 1'b1;
                lowest = NUM_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (active.vld) begin
            if (ack) active <= '0;
        end else if (found) begin
            active <= '{vld: 1'b1, num: lowest};
        end
    end
endmodule

// File: rtl/irqc_softrst.sv
module irqc_softrst #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (start) begin
            busy <= 1'b1;
            done <= 1'b0;
            cnt  <= CW'(CYCLES - 1);
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS   = 3,
    parameter int SRST_CYCLES = 4,
    parameter int REV_MAJOR   = 2,
    parameter int REV_MINOR   = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BANKS*BANK_W-1:0] irq_lvl,
    input  logic                        bus_sel,
    input  logic                        bus_we,
    input  logic [11:0]                 bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic                        irq_req
);
    localparam int NUM_IRQ = NUM_BANKS * BANK_W;

    dec_t               dec;
    logic               wr;
    logic               sr_busy, sr_done, sr_start;
    logic               local_rst;
    logic [NUM_IRQ-1:0] mask_all, pend_all;
    active_t            active;
    logic [NUM_W-1:0]   active_num;

    logic               autoidle;
    logic [31:0]        prot_q, idle_q, thresh_q;
    logic [31:0]        lvl_regs [NUM_IRQ];

    assign dec        = decode_addr(bus_addr, NUM_BANKS);
    assign wr         = bus_sel && bus_we && !sr_busy;
    assign sr_start   = wr && dec.kind == K_SYSCFG && bus_wdata[1];
    assign local_rst  = rst || sr_busy;
    assign active_num = active.num;
    assign irq_req    = active.vld;

    irqc_softrst #(.CYCLES(SRST_CYCLES)) u_srst (
        .clk(clk), .rst(rst), .start(sr_start), .busy(sr_busy), .done(sr_done)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqc_bank #(.W(BANK_W)) u_bank (
            .clk    (clk),
            .rst    (local_rst),
            .wr_mask(wr && dec.kind == K_MASK && dec.bank == 2'(b)),
            .wr_set (wr && dec.kind == K_SET  && dec.bank == 2'(b)),
            .wr_clr (wr && dec.kind == K_CLR  && dec.bank == 2'(b)),
            .wdata  (bus_wdata),
            .lvl    (irq_lvl[b*BANK_W +: BANK_W]),
            .mask   (mask_all[b*BANK_W +: BANK_W]),
            .pend   (pend_all[b*BANK_W +: BANK_W])
        );
    end

    irqc_arbiter #(.N(NUM_IRQ)) u_arb (
        .clk   (clk),
        .rst   (local_rst),
        .pend  (pend_all),
        .ack   (wr && dec.kind == K_CTRL && bus_wdata[0]),
        .active(active)
    );

    // Plain storage registers
    always_ff @(posedge clk) begin
        if (local_rst) begin
            autoidle <= 1'b0;
            prot_q   <= '0;
            idle_q   <= '0;
            thresh_q <= '0;
            for (int i = 0; i < NUM_IRQ; i++) lvl_regs[i] <= '0;
        end else if (wr) begin
            case (dec.kind)
                K_SYSCFG: if (!bus_wdata[1]) autoidle <= bus_wdata[0];
                K_PROT:   prot_q   <= bus_wdata;
                K_IDLE:   idle_q   <= bus_wdata;
                K_THRESH: thresh_q <= bus_wdata;
                K_LVL:    lvl_regs[dec.idx] <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (dec.kind)
                K_REV:     bus_rdata = {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
                K_SYSCFG:  bus_rdata = {31'd0, autoidle};
                K_SYSSTAT: bus_rdata = {31'd0, sr_done};
                K_ACTIVE:  bus_rdata = {{(32-NUM_W){1'b0}}, active.num};
                K_PROT:    bus_rdata = prot_q;
                K_IDLE:    bus_rdata = idle_q;
                K_THRESH:  bus_rdata = thresh_q;
                K_MASK:    bus_rdata = mask_all[int'(dec.bank)*BANK_W +: BANK_W];
                K_PEND:    bus_rdata = pend_all[int'(dec.bank)*BANK_W +: BANK_W];
                K_LVL:     bus_rdata = lvl_regs[dec.idx];
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        bus_sel,
    input logic                        bus_we,
    input logic [11:0]                 bus_addr,
    input logic [31:0]                 bus_wdata,
    input logic                        irq_req,
    input logic [NUM_BANKS*BANK_W-1:0] pend_all,
    input logic [NUM_BANKS*BANK_W-1:0] mask_all,
    input logic [NUM_W-1:0]            act_num,
    input logic                        sr_busy,
    input logic                        sr_done
);
    localparam int NUM_IRQ = NUM_BANKS * BANK_W;
    localparam logic [NUM_IRQ-1:0] ONE = NUM_IRQ'(1);

    logic               wr_any, ack_wr, srst_wr;
    logic [NUM_IRQ-1:0] pend_q;

    assign wr_any  = bus_sel && bus_we && !sr_busy;
    assign ack_wr  = wr_any && bus_addr == 12'(OFF_CTRL) && bus_wdata[0];
    assign srst_wr = wr_any && bus_addr == 12'(OFF_SYSCFG) && bus_wdata[1];

    always_ff @(posedge clk) pend_q <= pend_all;

    // R5
    lowest_pick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> pend_q[act_num] && ((pend_q & ((ONE << act_num) - ONE)) == '0));

    // R5
    select_go_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && (|pend_all) && !sr_busy && !srst_wr) |=> irq_req);

    // R6
    hold_num_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !ack_wr && !sr_busy && !srst_wr) |=> (irq_req && $stable(act_num)));

    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && ack_wr) |=> !irq_req);

    // R8
    srst_flag_chk: assert property (@(posedge clk) disable iff (rst)
        srst_wr |=> !sr_done);

    // R8
    srst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sr_busy |=> !irq_req);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mchk
        // R2
        set_alias_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_any && bus_addr == 12'(OFF_SET + b * BANK_STRIDE))
            |=> ((mask_all[b*BANK_W +: BANK_W] & $past(bus_wdata)) == $past(bus_wdata)));
        // R3
        clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_any && bus_addr == 12'(OFF_CLR + b * BANK_STRIDE))
            |=> ((mask_all[b*BANK_W +: BANK_W] & $past(bus_wdata)) == '0));
    end
endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .irq_req  (irq_req),
    .pend_all (pend_all),
    .mask_all (mask_all),
    .act_num  (active_num),
    .sr_busy  (sr_busy),
    .sr_done  (sr_done)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
    localparam int NB   = 3;
    localparam int NI   = NB * 32;
    localparam int NVEC = 6;
    localparam int SRST = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NI-1:0] irq_lvl = '0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_req;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    irq_ctrl #(.NUM_BANKS(NB), .SRST_CYCLES(SRST)) u_irq_ctrl (
        .clk(clk), .rst(rst), .irq_lvl(irq_lvl), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    // Stimulus table: input levels, unmask pattern, expected latched number (255 = none)
    localparam logic [NI-1:0] VEC_LVL [NVEC] = '{
        NI'(1) << 5,
        (NI'(1) << 40) | (NI'(1) << 70),
        (NI'(1) << 3) | (NI'(1) << 64),
        NI'(1) << 95,
        (NI'(1) << 0) | (NI'(1) << 31),
        (NI'(1) << 33) | (NI'(1) << 34)
    };
    localparam logic [NI-1:0] VEC_UNM [NVEC] = '{
        {NI{1'b1}},
        {NI{1'b1}},
        ~(NI'(1) << 3),
        {NI{1'b1}},
        {NI{1'b1}},
        {NI{1'b0}}
    };
    localparam logic [7:0] VEC_NUM [NVEC] = '{8'd5, 8'd40, 8'd64, 8'd95, 8'd0, 8'd255};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic mask_all_banks();
        for (int b = 0; b < NB; b++) bus_write(12'('h8C + 'h20 * b), 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        irq_lvl = '1;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state while all inputs asserted
        chk("R1 irq_req", 32'(irq_req), 32'd0);
        for (int b = 0; b < NB; b++) begin
            bus_read(12'('h84 + 'h20 * b), rd); chk("R1 mask", rd, 32'hFFFF_FFFF);
            bus_read(12'('h98 + 'h20 * b), rd); chk("R1 pending", rd, 32'd0);
        end
        bus_read(12'h014, rd); chk("R1 status", rd, 32'd1);
        bus_read(12'h040, rd); chk("R1 active", rd, 32'd0);
        repeat (3) @(negedge clk);
        chk("R1 irq_req held low", 32'(irq_req), 32'd0);
        irq_lvl = '0;

        // R12
        bus_read(12'h000, rd); chk("R12 revision", rd, 32'h21);

        // R2 / R3 mask manipulation on bank 1 and bank 2
        bus_write(12'h0A8, 32'h0000_00F0);
        bus_read(12'h0A4, rd); chk("R3 clear alias", rd, 32'hFFFF_FF0F);
        bus_write(12'h0AC, 32'h0000_0030);
        bus_read(12'h0A4, rd); chk("R2 set alias", rd, 32'hFFFF_FF3F);
        bus_write(12'h0C4, 32'h1234_5678);
        bus_read(12'h0C4, rd); chk("R3 direct mask", rd, 32'h1234_5678);
        mask_all_banks();
        bus_read(12'h0C4, rd); chk("R2 set all", rd, 32'hFFFF_FFFF);

        // Table walk: R4, R5, R7
        for (int v = 0; v < NVEC; v++) begin
            irq_lvl = VEC_LVL[v];
            for (int b = 0; b < NB; b++) bus_write(12'('h88 + 'h20 * b), VEC_UNM[v][b*32 +: 32]);
            repeat (2) @(negedge clk);
            for (int b = 0; b < NB; b++) begin
                bus_read(12'('h98 + 'h20 * b), rd);
                chk("R4 pending", rd, VEC_LVL[v][b*32 +: 32] & VEC_UNM[v][b*32 +: 32]);
            end
            if (VEC_NUM[v] != 8'd255) begin
                chk("R5 irq_req", 32'(irq_req), 32'd1);
                bus_read(12'h040, rd); chk("R5 lowest number", rd, 32'(VEC_NUM[v]));
                bus_write(12'h048, 32'd1);
                chk("R7 ack drops irq_req", 32'(irq_req), 32'd0);
            end else begin
                chk("R4 masked lines give no request", 32'(irq_req), 32'd0);
            end
            irq_lvl = '0;
            mask_all_banks();
        end

        // R6 / R7: hold through input changes and masking, reselect after ack
        for (int b = 0; b < NB; b++) bus_write(12'('h88 + 'h20 * b), 32'hFFFF_FFFF);
        irq_lvl = (NI'(1) << 40) | (NI'(1) << 70);
        repeat (2) @(negedge clk);
        bus_read(12'h040, rd); chk("R5 picks 40", rd, 32'd40);
        irq_lvl = NI'(1) << 70;
        repeat (3) @(negedge clk);
        chk("R6 irq_req held", 32'(irq_req), 32'd1);
        bus_read(12'h040, rd); chk("R6 number held", rd, 32'd40);
        bus_write(12'h048, 32'd1);
        chk("R7 gap after ack", 32'(irq_req), 32'd0);
        @(negedge clk);
        chk("R7 reselect next cycle", 32'(irq_req), 32'd1);
        bus_read(12'h040, rd); chk("R7 reselect number", rd, 32'd70);
        bus_write(12'h0CC, 32'h0000_0040);
        bus_read(12'h040, rd); chk("R6 held after mask", rd, 32'd70);
        chk("R6 irq_req after mask", 32'(irq_req), 32'd1);
        bus_write(12'h048, 32'd1);
        repeat (2) @(negedge clk);
        chk("R7 nothing left", 32'(irq_req), 32'd0);
        bus_read(12'h040, rd); chk("R7 active cleared", rd, 32'd0);
        irq_lvl = '0;

        // R9 autoidle storage
        bus_write(12'h010, 32'd1);
        bus_read(12'h010, rd); chk("R9 autoidle set", rd, 32'd1);
        bus_write(12'h010, 32'd0);
        bus_read(12'h010, rd); chk("R9 autoidle clear", rd, 32'd0);
        bus_write(12'h010, 32'd1);

        // R10 storage registers
        bus_write(12'h04C, 32'hA5A5_0001);
        bus_write(12'h050, 32'h0000_0003);
        bus_write(12'h068, 32'h0000_00FF);
        bus_write(12'h100, 32'h0000_0011);
        bus_write(12'h27C, 32'hDEAD_BEEF);
        bus_read(12'h04C, rd); chk("R10 protection", rd, 32'hA5A5_0001);
        bus_read(12'h050, rd); chk("R10 idle", rd, 32'h0000_0003);
        bus_read(12'h068, rd); chk("R10 threshold", rd, 32'h0000_00FF);
        bus_read(12'h100, rd); chk("R10 level word 0", rd, 32'h0000_0011);
        bus_read(12'h27C, rd); chk("R10 level word 95", rd, 32'hDEAD_BEEF);

        // R11 unmapped and write-only offsets
        bus_read(12'h004, rd); chk("R11 offset 0x004", rd, 32'd0);
        bus_read(12'h048, rd); chk("R11 control", rd, 32'd0);
        bus_read(12'h088, rd); chk("R11 clear alias", rd, 32'd0);
        bus_read(12'h0AC, rd); chk("R11 set alias", rd, 32'd0);
        bus_read(12'h280, rd); chk("R11 past level words", rd, 32'd0);
        bus_read(12'hFFC, rd); chk("R11 top offset", rd, 32'd0);

        // R8 soft reset with a live interrupt
        bus_write(12'h088, 32'h0000_0004);
        irq_lvl = NI'(1) << 2;
        repeat (2) @(negedge clk);
        chk("R8 precondition irq", 32'(irq_req), 32'd1);
        bus_write(12'h010, 32'h0000_0002);
        bus_write(12'h04C, 32'h0000_0077);
        bus_read(12'h014, rd); chk("R8 done flag low", rd, 32'd0);
        repeat (SRST + 3) @(negedge clk);
        bus_read(12'h014, rd); chk("R8 done flag high", rd, 32'd1);
        bus_read(12'h084, rd); chk("R8 mask restored", rd, 32'hFFFF_FFFF);
        bus_read(12'h010, rd); chk("R8 autoidle cleared", rd, 32'd0);
        bus_read(12'h04C, rd); chk("R8 write during reset ignored", rd, 32'd0);
        bus_read(12'h27C, rd); chk("R8 level word cleared", rd, 32'd0);
        chk("R8 irq_req after reset", 32'(irq_req), 32'd0);
        irq_lvl = '0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule